// File: doc/BRIEF.md
# Block Transfer and Scan Engine

This engine runs the byte-block instructions of an 8-bit processor core after the decoder has picked one. It has two jobs. In transfer mode it reads a byte at a source pointer and writes it to a target pointer. In scan mode it reads a byte at a source pointer and compares it with the accumulator. After each byte it steps the pointers up or down by one and decrements a 16-bit count. A one-shot operation handles exactly one byte. A looping operation keeps going until its own stop rule fires.

The core starts an operation with a one-cycle `start` pulse. That pulse carries three mode bits and the current register values: source, target, count, accumulator, flags and the remaining cycle budget. The engine talks to memory through a synchronous port, where read data arrives one cycle after the request. When it finishes it raises `done` for one cycle. At that point the outputs hold the updated registers and flags, the adjusted budget, and a request to step the program counter back by 2 so that the interrupted loop will restart.

Top module: `blkmv_engine`

## Requirements
- R1: In transfer mode, each byte read at the source pointer is written unchanged to the target pointer in the cycle right after the read request. A write is never issued without a read just before it.
- R2: After each byte the source pointer moves by one: up when `op_down`=0 and down when `op_down`=1. In transfer mode the target pointer moves the same way. In scan mode the target pointer is left unchanged.
- R3: After each byte the count decrements by one.
- R4: A one-shot transfer returns the input flags with N (bit 1), H (bit 4) and P/V (bit 2) cleared. P/V is then set if the final count is nonzero. A one-shot operation never requests a program-counter rewind and leaves the budget unchanged.
- R5: A looping transfer charges 21 from the budget for each byte. It continues while the count is nonzero and the budget is above zero. If it stops with a nonzero count, it sets N (P/V and H cleared) and requests a rewind. If the count reached zero, it adds 5 back to the budget.
- R6: A scan computes the 8-bit difference `diff` = accumulator minus memory byte. The flags are then set as follows. N is set. C is kept. S is `diff` bit 7. Z is set when `diff` is 0. H is bit 4 of accumulator XOR byte XOR `diff`. P/V is set when the count is nonzero. Bits 5 and 3 read 0.
- R7: A looping scan stops after the byte whose difference is zero, or when the count reaches zero. It requests a rewind only when both the count and the difference are still nonzero. Otherwise it adds 5 back to the budget.
- R8: A looping scan charges 21 per byte. When scanning upward it also stops once the budget is at or below zero. When scanning downward it ignores the budget.
- R9: Pointers and the count wrap modulo 2^16. A looping operation that starts with a count of 0 goes through 0xFFFF and keeps going until another stop rule fires.
- R10: A `start` pulse that arrives while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `mem_req` and all result outputs are 0. `done` is high for exactly one cycle per operation, and `busy` is low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when idle |
| op_search | input | 1 | 1 = scan mode, 0 = transfer mode |
| op_down | input | 1 | 1 = pointers step down |
| op_repeat | input | 1 | 1 = looping operation |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial target pointer |
| cnt_in | input | 16 | Initial byte count |
| acc_in | input | 8 | Accumulator for scans |
| flags_in | input | 8 | Flags before the operation |
| budget_in | input | 16 | Signed remaining cycle budget |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| src_out | output | 16 | Updated source pointer |
| dst_out | output | 16 | Updated target pointer |
| cnt_out | output | 16 | Updated count |
| flags_out | output | 8 | Updated flags |
| budget_out | output | 16 | Updated signed budget |
| pc_rewind | output | 1 | Request to step the program counter back by 2 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach are the early stops of the looping modes. There the loop halts on the budget with data still left, and the two scan directions must disagree about whether the budget matters. The stimulus reaches them with small budgets chosen so that the budget runs out after a known number of bytes. It also uses a downward scan whose match lies beyond the point where the budget has gone negative. A separate run starts with a count of zero and a budget that stops it after three bytes, so the count wrap can be seen without sweeping 65536 bytes.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    localparam int FLG_S = 7;
    localparam int FLG_Z = 6;
    localparam int FLG_H = 4;
    localparam int FLG_P = 2;
    localparam int FLG_N = 1;
    localparam int FLG_C = 0;

    typedef logic [ADDR_W-1:0] word_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EXEC, ST_DONE} state_e;

    typedef struct packed {
        logic search;
        logic down;
        logic rpt;
    } opmode_t;

    function automatic word_t step_ptr(word_t p, logic down);
        return down ? p - word_t'(1) : p + word_t'(1);
    endfunction
endpackage

// File: rtl/blkmv_flags.sv
module blkmv_flags import blkmv_pkg::*; (
    input  opmode_t mode,
    input  byte_t   flags_cur,
    input  byte_t   acc,
    input  byte_t   mem_byte,
    input  logic    cnt_nz,
    output byte_t   flags_nxt,
    output logic    diff_nz
);
    byte_t diff;
    byte_t hx;

    assign diff    = acc - mem_byte;
    assign hx      = acc ^ mem_byte ^ diff;
    assign diff_nz = (diff != '0);

    always_comb begin
        flags_nxt = flags_cur;
        if (!mode.search) begin
            flags_nxt[FLG_N] = 1'b0;
            flags_nxt[FLG_H] = 1'b0;
            flags_nxt[FLG_P] = 1'b0;
            if (mode.rpt) flags_nxt[FLG_N] = cnt_nz;
            else          flags_nxt[FLG_P] = cnt_nz;
        end else begin
            flags_nxt        = '0;
            flags_nxt[FLG_C] = flags_cur[FLG_C];
            flags_nxt[FLG_N] = 1'b1;
            flags_nxt[FLG_S] = diff[DATA_W-1];
            flags_nxt[FLG_Z] = ~diff_nz;
            flags_nxt[FLG_H] = hx[4];
            flags_nxt[FLG_P] = cnt_nz;
        end
    end
endmodule

// File: rtl/blkmv_step.sv
module blkmv_step import blkmv_pkg::*; #(
    parameter int BUDGET_W   = 16,
    parameter int BYTE_COST  = 21,
    parameter int END_CREDIT = 5
) (
    input  opmode_t                    mode,
    input  word_t                      src,
    input  word_t                      dst,
    input  word_t                      cnt,
    input  logic signed [BUDGET_W-1:0] budget,
    input  logic                       diff_nz,
    output word_t                      src_n,
    output word_t                      dst_n,
    output word_t                      cnt_n,
    output logic                       cnt_nz,
    output logic signed [BUDGET_W-1:0] budget_n,
    output logic                       more,
    output logic                       rewind
);
    logic signed [BUDGET_W-1:0] charged;
    logic                       funds_ok;

    assign src_n   = step_ptr(src, mode.down);
    assign dst_n   = mode.search ? dst : step_ptr(dst, mode.down);
    assign cnt_n   = cnt - word_t'(1);
    assign cnt_nz  = (cnt_n != '0);
    assign charged = mode.rpt ? budget - BUDGET_W'(BYTE_COST) : budget;
    assign funds_ok = (charged > 0);

    always_comb begin
        if (!mode.rpt)
            more = 1'b0;
        else if (!mode.search)
            more = cnt_nz && funds_ok;
        else
            more = cnt_nz && diff_nz && (mode.down || funds_ok);
    end

    assign rewind   = mode.rpt && cnt_nz && (!mode.search || diff_nz);
    assign budget_n = (mode.rpt && !more && !rewind) ?
                      charged + BUDGET_W'(END_CREDIT) : charged;
endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine import blkmv_pkg::*; #(
    parameter int BUDGET_W   = 16,
    parameter int BYTE_COST  = 21,
    parameter int END_CREDIT = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                op_search,
    input  logic                op_down,
    input  logic                op_repeat,
    input  logic [ADDR_W-1:0]   src_in,
    input  logic [ADDR_W-1:0]   dst_in,
    input  logic [ADDR_W-1:0]   cnt_in,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic [DATA_W-1:0]   flags_in,
    input  logic [BUDGET_W-1:0] budget_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]   src_out,
    output logic [ADDR_W-1:0]   dst_out,
    output logic [ADDR_W-1:0]   cnt_out,
    output logic [DATA_W-1:0]   flags_out,
    output logic [BUDGET_W-1:0] budget_out,
    output logic                pc_rewind,
    output logic                busy,
    output logic                done
);
    state_e                     state_q;
    opmode_t                    mode_q;
    word_t                      src_q, dst_q, cnt_q;
    byte_t                      acc_q, flags_q;
    logic signed [BUDGET_W-1:0] budget_q;
    logic                       rewind_q;

    word_t                      src_n, dst_n, cnt_n;
    logic signed [BUDGET_W-1:0] budget_n;
    byte_t                      flags_n;
    logic                       cnt_nz, diff_nz, more, rewind_n;
    logic                       exec_w;

    assign exec_w = (state_q == ST_EXEC);

    blkmv_flags u_flags (
        .mode      (mode_q),
        .flags_cur (flags_q),
        .acc       (acc_q),
        .mem_byte  (mem_rdata),
        .cnt_nz    (cnt_nz),
        .flags_nxt (flags_n),
        .diff_nz   (diff_nz)
    );

    blkmv_step #(
        .BUDGET_W   (BUDGET_W),
        .BYTE_COST  (BYTE_COST),
        .END_CREDIT (END_CREDIT)
    ) u_step (
        .mode     (mode_q),
        .src      (src_q),
        .dst      (dst_q),
        .cnt      (cnt_q),
        .budget   (budget_q),
        .diff_nz  (diff_nz),
        .src_n    (src_n),
        .dst_n    (dst_n),
        .cnt_n    (cnt_n),
        .cnt_nz   (cnt_nz),
        .budget_n (budget_n),
        .more     (more),
        .rewind   (rewind_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            mode_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            acc_q    <= '0;
            flags_q  <= '0;
            budget_q <= '0;
            rewind_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    mode_q   <= '{search: op_search, down: op_down, rpt: op_repeat};
                    src_q    <= src_in;
                    dst_q    <= dst_in;
                    cnt_q    <= cnt_in;
                    acc_q    <= acc_in;
                    flags_q  <= flags_in;
                    budget_q <= budget_in;
                    rewind_q <= 1'b0;
                    state_q  <= ST_READ;
                end
                ST_READ: state_q <= ST_EXEC;
                ST_EXEC: begin
                    src_q    <= src_n;
                    dst_q    <= dst_n;
                    cnt_q    <= cnt_n;
                    flags_q  <= flags_n;
                    budget_q <= budget_n;
                    rewind_q <= rewind_n;
                    state_q  <= more ? ST_READ : ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (state_q == ST_READ) || (exec_w && !mode_q.search);
    assign mem_we     = exec_w && !mode_q.search;
    assign mem_addr   = exec_w ? dst_q : src_q;
    assign mem_wdata  = mem_rdata;

    assign src_out    = src_q;
    assign dst_out    = dst_q;
    assign cnt_out    = cnt_q;
    assign flags_out  = flags_q;
    assign budget_out = budget_q;
    assign pc_rewind  = rewind_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DONE);
endmodule

// File: rtl/blkmv_chk.sv
module blkmv_chk import blkmv_pkg::*; (
    input logic    clk,
    input logic    rst,
    input logic    done,
    input logic    busy,
    input logic    mem_req,
    input logic    mem_we,
    input word_t   src_out,
    input word_t   cnt_out,
    input byte_t   flags_out,
    input logic    pc_rewind,
    input logic    exec_w,
    input opmode_t mode_q
);
    assert_write_after_read_R1: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(mem_req && !mem_we));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
        exec_w |=> src_out == (mode_q.down ? $past(src_out) - word_t'(1)
                                           : $past(src_out) + word_t'(1)));

    assert_cnt_dec_R3: assert property (@(posedge clk) disable iff (rst)
        exec_w |=> cnt_out == $past(cnt_out) - word_t'(1));

    assert_oneshot_norewind_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q.rpt) |-> !pc_rewind);

    assert_copy_rewind_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q.search && mode_q.rpt) |-> (pc_rewind == (cnt_out != '0)));

    assert_scan_nflag_R6: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q.search) |-> flags_out[FLG_N]);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind blkmv_engine blkmv_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .src_out   (src_out),
    .cnt_out   (cnt_out),
    .flags_out (flags_out),
    .pc_rewind (pc_rewind),
    .exec_w    (exec_w),
    .mode_q    (mode_q)
);

// File: tb/blkmv_engine_tb.sv
module blkmv_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_search = 1'b0, op_down = 1'b0, op_repeat = 1'b0;
    logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0, budget_in = '0;
    logic [7:0]  acc_in = '0, flags_in = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] src_out, dst_out, cnt_out, budget_out;
    logic [7:0]  flags_out;
    logic        pc_rewind, busy, done;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    blkmv_engine dut_i (
        .clk(clk), .rst(rst), .start(start),
        .op_search(op_search), .op_down(op_down), .op_repeat(op_repeat),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .acc_in(acc_in),
        .flags_in(flags_in), .budget_in(budget_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .flags_out(flags_out), .budget_out(budget_out),
        .pc_rewind(pc_rewind), .busy(busy), .done(done)
    );

    function automatic logic [7:0] init_byte(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    logic [7:0] mem [0:1023];
    logic [7:0] ref_mem [0:1023];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_byte(i);
        end else if (mem_req) begin
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:0]];
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    logic [15:0] q_s[$], q_d[$], q_c[$], q_b[$];
    logic [7:0]  q_f[$];
    logic        q_r[$];
    string       q_tag[$];

    always @(negedge clk) begin
        if (!rst && done) begin
            if (q_tag.size() == 0) begin
                chk("R11", "unexpected done", 32'd1, 32'd0);
            end else begin
                string t;
                t = q_tag.pop_front();
                chk(t, "src_out", 32'(src_out), 32'(q_s.pop_front()));
                chk(t, "dst_out", 32'(dst_out), 32'(q_d.pop_front()));
                chk(t, "cnt_out", 32'(cnt_out), 32'(q_c.pop_front()));
                chk(t, "flags_out", 32'(flags_out), 32'(q_f.pop_front()));
                chk(t, "budget_out", 32'(budget_out), 32'(q_b.pop_front()));
                chk(t, "pc_rewind", 32'(pc_rewind), 32'(q_r.pop_front()));
            end
        end
    end

    // Reference model and driver: expected results go into the queues.
    task automatic run_op(string tag, logic srch, logic dn, logic rp,
                          logic [15:0] s0, logic [15:0] d0, logic [15:0] c0,
                          logic [7:0] acc, logic [7:0] f0, logic signed [15:0] b0,
                          logic poke_busy);
        logic [15:0] s, d, c;
        logic signed [15:0] b;
        logic [7:0] m, diff, f, hx;
        logic more, rw;
        s = s0; d = d0; c = c0; b = b0; diff = 8'h00; m = 8'h00;
        do begin
            m = ref_mem[s[9:0]];
            if (!srch) begin
                ref_mem[d[9:0]] = m;
                d = dn ? d - 16'd1 : d + 16'd1;
            end
            diff = acc - m;
            s = dn ? s - 16'd1 : s + 16'd1;
            c = c - 16'd1;
            if (rp) b = b - 16'sd21;
            if (!rp)        more = 1'b0;
            else if (!srch) more = (c != 0) && (b > 0);
            else            more = (c != 0) && (diff != 0) && (dn || b > 0);
        end while (more);
        if (!srch) begin
            f = f0 & 8'hE9;
            if (rp) f[1] = (c != 0); else f[2] = (c != 0);
            rw = rp && (c != 0);
        end else begin
            hx = acc ^ m ^ diff;
            f = {diff[7], diff == 8'h00, 1'b0, hx[4], 1'b0, c != 0, 1'b1, f0[0]};
            rw = rp && (c != 0) && (diff != 0);
        end
        if (rp && !rw) b = b + 16'sd5;
        q_s.push_back(s); q_d.push_back(d); q_c.push_back(c);
        q_f.push_back(f); q_b.push_back(b); q_r.push_back(rw); q_tag.push_back(tag);

        @(negedge clk);
        op_search = srch; op_down = dn; op_repeat = rp;
        src_in = s0; dst_in = d0; cnt_in = c0; acc_in = acc;
        flags_in = f0; budget_in = b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R10: a second start while busy must change nothing
            src_in = 16'h0300; dst_in = 16'h0310; cnt_in = 16'd2; op_search = 1'b0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(tag, "busy after done (R11)", 32'(busy), 32'd0);
    endtask

    task automatic mem_chk(string tag, int lo, int hi);
        for (int i = lo; i <= hi; i++)
            chk(tag, "memory byte", 32'(mem[i]), 32'(ref_mem[i]));
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) ref_mem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset busy", 32'(busy), 32'd0);
        chk("R11", "reset done", 32'(done), 32'd0);
        chk("R11", "reset mem_req", 32'(mem_req), 32'd0);
        chk("R11", "reset cnt_out", 32'(cnt_out), 32'd0);
        chk("R11", "reset flags_out", 32'(flags_out), 32'd0);

        // R1 R2 R4: one-shot transfer upward, count stays nonzero
        run_op("R4", 0, 0, 0, 16'h0020, 16'h0200, 16'd3, 8'h00, 8'hFF, 16'sd100, 0);
        mem_chk("R1", 16'h200, 16'h200);
        // R4: one-shot transfer downward, count reaches zero
        run_op("R4", 0, 1, 0, 16'h0030, 16'h0210, 16'd1, 8'h00, 8'h16, 16'sd100, 0);
        // R5: looping transfer runs to completion
        run_op("R5", 0, 0, 1, 16'h0040, 16'h0220, 16'd8, 8'h00, 8'h01, 16'sd1000, 0);
        mem_chk("R1", 16'h220, 16'h227);
        // R5: looping transfer suspended by budget after two bytes
        run_op("R5", 0, 0, 1, 16'h0050, 16'h0240, 16'd5, 8'h00, 8'h00, 16'sd30, 0);
        mem_chk("R2", 16'h23F, 16'h244);
        // R6: one-shot scans with several accumulator and carry patterns
        run_op("R6", 1, 0, 0, 16'h0060, 16'h0000, 16'd4, 8'h10, 8'h01, 16'sd50, 0);
        run_op("R6", 1, 1, 0, 16'h0061, 16'h0000, 16'd1, init_byte(16'h61), 8'hFE, 16'sd50, 0);
        run_op("R6", 1, 0, 0, 16'h0062, 16'h0000, 16'd9, 8'hF8, 8'h00, 16'sd50, 0);
        // R7: looping upward scan stops on the match
        run_op("R7", 1, 0, 1, 16'h0080, 16'h0000, 16'd20, init_byte(16'h85), 8'h00, 16'sd1000, 0);
        // R7: looping scan exhausts the count without a match
        run_op("R7", 1, 0, 1, 16'h0090, 16'h0000, 16'd4, init_byte(16'h3A0), 8'h01, 16'sd1000, 0);
        // R8: upward scan suspended by budget
        run_op("R8", 1, 0, 1, 16'h00A0, 16'h0000, 16'd10, init_byte(16'h3B0), 8'h00, 16'sd25, 0);
        // R8: downward scan ignores budget and reaches a match
        run_op("R8", 1, 1, 1, 16'h00C0, 16'h0000, 16'd20, init_byte(16'hBB), 8'h00, 16'sd10, 0);
        // R9: count starting at zero wraps, stopped by budget after three bytes
        run_op("R9", 0, 0, 1, 16'h0100, 16'h0280, 16'd0, 8'h00, 8'h00, 16'sd50, 0);
        // R9: pointer wrap at both ends
        run_op("R9", 0, 0, 0, 16'hFFFF, 16'h0000, 16'd2, 8'h00, 8'h00, 16'sd5, 0);
        mem_chk("R9", 16'h3FF, 16'h3FF);
        // R10: start pulse during busy is ignored
        run_op("R10", 0, 0, 1, 16'h0110, 16'h02A0, 16'd4, 8'h00, 8'h00, 16'sd500, 1);
        mem_chk("R10", 16'h310, 16'h311);
        repeat (4) begin
            @(negedge clk);
            chk("R10", "no extra done", 32'(done), 32'd0);
        end
        chk("R11", "queue drained", 32'(q_tag.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule